// File: doc/BRIEF.md
# Hardware Thread Context Run-State Tracker

This block keeps the run state of a fixed set of hardware thread contexts on one processor. Each context always holds one of four states: free (no thread assigned), running, parked (waiting, for example on synchronization) or stopped (shut down for good). Four request lines per context move it between these states:

- wake, which carries a delay count;
- park;
- free;
- stop.

The block presents each context's state, an execute-enable that the pipeline uses to issue from that context, and a global flag that tells the system every context has stopped.

A wake request does not take effect at once. It arms a per-context countdown, and the context turns running only when the countdown expires. Any other request that reaches the context while the countdown runs cancels it. Stopped is terminal and only reset leaves it. Scheduling, register state and instruction execution belong to other blocks.

Top module: `ctx_status_tracker`

## Requirements
- R1: While reset is high and after it falls, before any request, every context reads free, no execute-enable is high, and the all-stopped flag is low.
- R2: Each context's state is a 2-bit field at bits [2i+1:2i] of `ctx_state`, encoded 00 free, 01 running, 10 parked, 11 stopped.
- R3: A wake request with delay D (1 to 255) sampled at a clock edge makes the context read running after exactly D further edges; before that its state is unchanged.
- R4: A wake delay of 0 behaves exactly like a delay of 1.
- R5: `run_en[i]` is high exactly when context i reads running.
- R6: A park request on a context that is not stopped makes it read parked after the next edge.
- R7: A free request on a context that is not stopped makes it read free after the next edge.
- R8: A stop request makes the context read stopped after the next edge, and it then stays stopped under any request until reset.
- R9: When several requests reach one context in the same cycle, stop wins over free, free over park, and park over wake.
- R10: Any request sampled while a wake countdown is pending cancels that countdown, including in the cycle it would expire. A new wake restarts the countdown with its own delay.
- R11: `all_stopped` is high exactly when every context reads stopped.
- R12: Requests on one context never change the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | NUM_CTX | Per-context wake request |
| wake_delay | input | NUM_CTX*DELAY_W | Per-context wake delay, context i at bits [DELAY_W*i +: DELAY_W] |
| park_req | input | NUM_CTX | Per-context park request |
| free_req | input | NUM_CTX | Per-context free request |
| stop_req | input | NUM_CTX | Per-context stop request |
| ctx_state | output | 2*NUM_CTX | Per-context state, encoded as in R2 |
| run_en | output | NUM_CTX | Per-context execute-enable |
| all_stopped | output | 1 | High when every context is stopped |

## Verification
Two functions can land on the same context in the same cycle:

- the expiry of a pending wake countdown and a fresh request;
- several requests at once, which the priority rule must resolve.

The bench provokes the first by timing a park or free request onto the exact edge where a countdown reaches zero. It provokes the second by raising all four request lines together, and also subsets of them. It judges the outcome against a bench model built from the priority and cancellation rules. That model is also compared cycle by cycle during a seeded random run that fires overlapping requests on all contexts.

// File: rtl/ctx_track_pkg.sv
package ctx_track_pkg;

    typedef enum logic [1:0] {
        CS_FREE = 2'b00,
        CS_RUN  = 2'b01,
        CS_PARK = 2'b10,
        CS_STOP = 2'b11
    } ctx_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WAKE,
        OP_PARK,
        OP_FREE,
        OP_STOP
    } ctx_op_e;

    typedef struct packed {
        logic wake;
        logic park;
        logic free;
        logic stop;
    } ctx_cmd_t;

    // Fixed precedence: stop, then free, then park, then wake.
    function automatic ctx_op_e pick_op(ctx_cmd_t c);
        if (c.stop)      return OP_STOP;
        else if (c.free) return OP_FREE;
        else if (c.park) return OP_PARK;
        else if (c.wake) return OP_WAKE;
        else             return OP_NONE;
    endfunction

endpackage

// File: rtl/ctx_cmd_arbiter.sv
module ctx_cmd_arbiter
    import ctx_track_pkg::*;
(
    input  ctx_cmd_t   cmd,
    input  ctx_state_e cur,
    output ctx_op_e    op
);
    // A stopped context accepts nothing.
    always_comb begin
        if (cur == CS_STOP) op = OP_NONE;
        else                op = pick_op(cmd);
    end
endmodule

// File: rtl/ctx_wake_timer.sv
module ctx_wake_timer #(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               cancel,
    input  logic [DELAY_W-1:0] delay_in,
    output logic               fire
);
    logic [DELAY_W-1:0] remain_q;
    logic               armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            remain_q <= '0;
        end else if (load) begin
            armed_q  <= 1'b1;
            remain_q <= (delay_in == '0) ? '0 : delay_in - 1'b1;
        end else if (cancel) begin
            armed_q  <= 1'b0;
        end else if (armed_q) begin
            if (remain_q == '0) armed_q <= 1'b0;
            else                remain_q <= remain_q - 1'b1;
        end
    end

    // A request in the expiry cycle overrides the expiry.
    assign fire = armed_q && (remain_q == '0) && !load && !cancel;
endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
    import ctx_track_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  ctx_cmd_t           cmd,
    input  logic [DELAY_W-1:0] delay_in,
    output ctx_state_e         state,
    output logic               run_en
);
    ctx_state_e state_q;
    ctx_op_e    op;
    logic       fire;
    logic       load;
    logic       cancel;

    ctx_cmd_arbiter u_arb (
        .cmd (cmd),
        .cur (state_q),
        .op  (op)
    );

    assign load   = (op == OP_WAKE);
    assign cancel = (op == OP_PARK) || (op == OP_FREE) || (op == OP_STOP);

    ctx_wake_timer #(.DELAY_W(DELAY_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .cancel   (cancel),
        .delay_in (delay_in),
        .fire     (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_FREE;
        end else begin
            unique case (op)
                OP_STOP: state_q <= CS_STOP;
                OP_FREE: state_q <= CS_FREE;
                OP_PARK: state_q <= CS_PARK;
                OP_WAKE: state_q <= state_q;
                default: if (fire) state_q <= CS_RUN;
            endcase
        end
    end

    assign state  = state_q;
    assign run_en = (state_q == CS_RUN);
endmodule

// File: rtl/ctx_status_tracker.sv
module ctx_status_tracker
    import ctx_track_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int DELAY_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CTX-1:0]         wake_req,
    input  logic [NUM_CTX*DELAY_W-1:0] wake_delay,
    input  logic [NUM_CTX-1:0]         park_req,
    input  logic [NUM_CTX-1:0]         free_req,
    input  logic [NUM_CTX-1:0]         stop_req,
    output logic [2*NUM_CTX-1:0]       ctx_state,
    output logic [NUM_CTX-1:0]         run_en,
    output logic                       all_stopped
);
    localparam int STATE_W = $bits(ctx_state_e);

    logic [NUM_CTX-1:0] stopped_vec;

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        ctx_cmd_t   cmd;
        ctx_state_e st;

        assign cmd.wake = wake_req[i];
        assign cmd.park = park_req[i];
        assign cmd.free = free_req[i];
        assign cmd.stop = stop_req[i];

        ctx_slot #(.DELAY_W(DELAY_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd),
            .delay_in (wake_delay[i*DELAY_W +: DELAY_W]),
            .state    (st),
            .run_en   (run_en[i])
        );

        assign ctx_state[i*STATE_W +: STATE_W] = st;
        assign stopped_vec[i] = (st == CS_STOP);
    end

    assign all_stopped = &stopped_vec;
endmodule

// File: rtl/ctx_status_checker.sv
module ctx_status_checker #(
    parameter int NUM_CTX = 4,
    parameter int DELAY_W = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_CTX-1:0]         wake_req,
    input logic [NUM_CTX*DELAY_W-1:0] wake_delay,
    input logic [NUM_CTX-1:0]         park_req,
    input logic [NUM_CTX-1:0]         free_req,
    input logic [NUM_CTX-1:0]         stop_req,
    input logic [2*NUM_CTX-1:0]       ctx_state,
    input logic [NUM_CTX-1:0]         run_en,
    input logic                       all_stopped
);
    a_r11_all_stopped: assert property (@(posedge clk) disable iff (rst)
        all_stopped == (ctx_state == {(2*NUM_CTX){1'b1}}));

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_chk
        a_r5_enable_is_running: assert property (@(posedge clk) disable iff (rst)
            run_en[i] == (ctx_state[2*i +: 2] == 2'b01));

        a_r8_stop_enters: assert property (@(posedge clk) disable iff (rst)
            stop_req[i] |=> ctx_state[2*i +: 2] == 2'b11);

        a_r8_stop_sticky: assert property (@(posedge clk) disable iff (rst)
            ctx_state[2*i +: 2] == 2'b11 |=> ctx_state[2*i +: 2] == 2'b11);

        a_r7_free_applies: assert property (@(posedge clk) disable iff (rst)
            (free_req[i] && !stop_req[i] && ctx_state[2*i +: 2] != 2'b11)
            |=> ctx_state[2*i +: 2] == 2'b00);

        a_r6_park_applies: assert property (@(posedge clk) disable iff (rst)
            (park_req[i] && !free_req[i] && !stop_req[i] && ctx_state[2*i +: 2] != 2'b11)
            |=> ctx_state[2*i +: 2] == 2'b10);

        a_r4_short_wake: assert property (@(posedge clk) disable iff (rst)
            (wake_req[i] && !park_req[i] && !free_req[i] && !stop_req[i]
             && ctx_state[2*i +: 2] != 2'b11
             && wake_delay[i*DELAY_W +: DELAY_W] <= 1)
            ##1 (!wake_req[i] && !park_req[i] && !free_req[i] && !stop_req[i])
            |=> ctx_state[2*i +: 2] == 2'b01);
    end
endmodule

bind ctx_status_tracker ctx_status_checker #(
    .NUM_CTX (NUM_CTX),
    .DELAY_W (DELAY_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wake_req    (wake_req),
    .wake_delay  (wake_delay),
    .park_req    (park_req),
    .free_req    (free_req),
    .stop_req    (stop_req),
    .ctx_state   (ctx_state),
    .run_en      (run_en),
    .all_stopped (all_stopped)
);

// File: tb/ctx_status_tracker_tb.sv
`timescale 1ns/1ps
module ctx_status_tracker_tb_top;
    localparam int N  = 4;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    wake, park, free, stop;
    logic [N*DW-1:0] dly;
    logic [2*N-1:0]  st;
    logic [N-1:0]    en;
    logic            done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_st   [N];
    bit m_pend [N];
    int m_cnt  [N];

    always #10 clk = ~clk;

    ctx_status_tracker #(.NUM_CTX(N), .DELAY_W(DW)) dut_i (
        .clk (clk), .rst (rst), .wake_req (wake), .wake_delay (dly),
        .park_req (park), .free_req (free), .stop_req (stop),
        .ctx_state (st), .run_en (en), .all_stopped (done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model taken from the requirements (R3, R4, R6 to R10).
    task automatic model_step();
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 3) continue;
            if (stop[i]) begin
                m_st[i] = 3; m_pend[i] = 0;
            end else if (free[i]) begin
                m_st[i] = 0; m_pend[i] = 0;
            end else if (park[i]) begin
                m_st[i] = 2; m_pend[i] = 0;
            end else if (wake[i]) begin
                int d;
                d = int'(dly[i*DW +: DW]);
                m_pend[i] = 1;
                m_cnt[i]  = (d == 0) ? 0 : d - 1;
            end else if (m_pend[i]) begin
                if (m_cnt[i] == 0) begin
                    m_st[i] = 1; m_pend[i] = 0;
                end else begin
                    m_cnt[i]--;
                end
            end
        end
    endtask

    task automatic check_all(input string tag);
        bit all3;
        all3 = 1;
        for (int i = 0; i < N; i++) begin
            check($sformatf("%s ctx%0d state", tag, i), int'(st[2*i +: 2]), m_st[i]);
            check($sformatf("R5 ctx%0d enable", i), int'(en[i]), int'(m_st[i] == 1));
            if (m_st[i] != 3) all3 = 0;
        end
        check("R11 all_stopped", int'(done), int'(all3));
    endtask

    task automatic cyc(input logic [N-1:0] w, input logic [N-1:0] p,
                       input logic [N-1:0] f, input logic [N-1:0] s,
                       input logic [N*DW-1:0] d, input string tag);
        wake = w; park = p; free = f; stop = s; dly = d;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc('0, '0, '0, '0, '0, tag);
    endtask

    function automatic logic [N*DW-1:0] dset(input int ctx, input int d);
        logic [N*DW-1:0] v;
        v = '0;
        v[ctx*DW +: DW] = DW'(d);
        return v;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        wake = '0; park = '0; free = '0; stop = '0; dly = '0;
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset");
    endtask

    initial begin
        void'($urandom(32'd20250611));
        do_reset();

        // R3: wake ctx0 with delay 3, no early activation
        cyc(4'b0001, '0, '0, '0, dset(0, 3), "R3 issue");
        idle(3, "R3 countdown");
        // R4: delay 0 acts as 1
        cyc(4'b0010, '0, '0, '0, dset(1, 0), "R4 issue");
        idle(1, "R4 one edge");
        // R6, R7 and R2 encodings
        cyc('0, 4'b0001, '0, '0, '0, "R6 park R2");
        cyc('0, '0, 4'b0001, '0, '0, "R7 free R2");
        // R9 priority
        cyc(4'b0100, 4'b0100, 4'b0100, 4'b0100, dset(2, 1), "R9 all four");
        cyc(4'b1000, 4'b1000, 4'b1000, '0, dset(3, 1), "R9 free wins");
        cyc(4'b1000, 4'b1000, '0, '0, dset(3, 1), "R9 park wins");
        // R8 stopped is sticky
        cyc(4'b0100, '0, '0, '0, dset(2, 1), "R8 wake ignored");
        cyc('0, 4'b0100, 4'b0100, '0, '0, "R8 park free ignored");
        idle(3, "R8 hold");
        // R10 cancel mid-countdown and in the expiry cycle
        cyc(4'b0001, '0, '0, '0, dset(0, 5), "R10 arm");
        idle(2, "R10 wait");
        cyc('0, 4'b0001, '0, '0, '0, "R10 park cancels");
        idle(6, "R10 no late run");
        cyc(4'b0001, '0, '0, '0, dset(0, 2), "R10 arm2");
        idle(1, "R10 wait2");
        cyc('0, '0, 4'b0001, '0, '0, "R10 free at expiry");
        idle(3, "R10 stays free");
        cyc(4'b0001, '0, '0, '0, dset(0, 6), "R10 arm3");
        idle(2, "R10 wait3");
        cyc(4'b0001, '0, '0, '0, dset(0, 2), "R10 rewake");
        idle(3, "R10 restart");
        // R3: longest delay
        cyc(4'b1000, '0, '0, '0, dset(3, 255), "R3 long");
        idle(256, "R3 long wait");

        // R12: seeded random mix, rare stop requests
        for (int c = 0; c < 600; c++) begin
            logic [N-1:0] w, p, f, s;
            logic [N*DW-1:0] d;
            for (int i = 0; i < N; i++) begin
                w[i] = ($urandom_range(0, 3) == 0);
                p[i] = ($urandom_range(0, 7) == 0);
                f[i] = ($urandom_range(0, 9) == 0);
                s[i] = (c > 300) && ($urandom_range(0, 150) == 0);
                d[i*DW +: DW] = DW'($urandom_range(0, 6));
            end
            cyc(w, p, f, s, d, "R12 random");
        end

        // R11: stop everything
        for (int i = 0; i < N; i++) cyc(4'(1 << i) ^ '0, '0, '0, 4'(1 << i), '0, "R11 stop one");
        idle(2, "R11 done held");
        do_reset();
        check("R1 done cleared", int'(done), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule